// File: doc/BRIEF.md
# Data Phase Termination Controller

This block follows the data phase of the bus transaction that the master currently owns. A transaction starts with a one-cycle request that carries its direction (read or write), its length (one beat or a full burst) and whether back-to-back streaming is allowed. From then on the block watches four inputs from the slave side: a transfer acknowledge, a data retry, a bus error and an address retry. It keeps the data-bus-busy line, counts the beats, and forwards a data-valid strobe with a beat number to the core one cycle after each acknowledged beat. When the transaction ends it reports completion, error or retry-required status.

On reads, a data retry means the data taken with the acknowledge one cycle earlier was bad. That beat is withdrawn and served again. This also works after the last beat, when the bus-busy line has already been released. The busy line is dropped for exactly one cycle after the final beat unless streaming is enabled for the transaction.

Top module: `dpt_term_ctrl`

## Requirements
- R1: While reset is held and in the first cycle after it, `bus_busy_o`, `beat_vld_o`, `done_o`, `err_o` and `retry_o` are all 0.
- R2: A start request is taken only when the block is idle or in the clean cycle after a final beat. `bus_busy_o` goes high in the cycle after the request is taken and stays high through any number of cycles without acknowledge. A start request at any other time changes nothing.
- R3: `burst_i`=1 selects `BURST_BEATS` beats and `burst_i`=0 selects one beat, sampled with the start request. Each accepted acknowledge produces `beat_vld_o`=1 in the following cycle, with `beat_idx_o` equal to the beat number counted from 0.
- R4: On a read, a data retry in the cycle after an acknowledge suppresses that cycle's `beat_vld_o`. The beat is not counted, and the next acknowledge carries the same beat number.
- R5: On a write, the data retry input has no effect on `beat_vld_o`, `beat_idx_o`, `bus_busy_o` or `done_o`.
- R6: In the cycle after the final acknowledge, `bus_busy_o` is 0 when streaming was not requested and 1 when it was. With a start request taken in that cycle, busy is therefore low for exactly one cycle, or not low at all when streaming.
- R7: On a read, a data retry in the cycle after the final acknowledge reopens the last beat. `bus_busy_o` stays 0 while it waits (1 only in the post-final cycle when streaming), no completion is reported, and a further acknowledge is needed.
- R8: `done_o` pulses for one cycle, once per transaction, two cycles after the final acknowledge, provided the cycle in between carried no read data retry, bus error or address retry.
- R9: A bus error during the data phase suppresses `beat_vld_o` in that cycle, pulses `err_o` in the next cycle with no `done_o`, and returns the block to idle.
- R10: An address retry during the data phase cancels the transaction: `beat_vld_o` is 0 in that cycle, `retry_o` pulses in the next cycle, no `done_o` follows, and the block returns to idle.
- R11: When several inputs arrive in the same cycle, a bus error wins over an address retry, and both win over an acknowledge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | Request to begin a data phase |
| rd_i | input | 1 | 1 = read, 0 = write; sampled with the request |
| burst_i | input | 1 | 1 = burst of BURST_BEATS beats, 0 = single beat |
| stream_i | input | 1 | Streaming mode: keep busy across the post-final cycle |
| xfer_ack_i | input | 1 | Transfer acknowledge for the current beat |
| data_retry_i | input | 1 | Read data of the previous cycle was invalid |
| bus_err_i | input | 1 | Nonrecoverable bus error |
| addr_retry_i | input | 1 | Address retry: transaction must be reissued |
| bus_busy_o | output | 1 | Data bus busy |
| beat_vld_o | output | 1 | Data beat forwarded to the core |
| beat_idx_o | output | IDX_W | Beat number of the forwarded beat |
| done_o | output | 1 | Transaction completed (one-cycle pulse) |
| err_o | output | 1 | Transaction ended by bus error (pulse) |
| retry_o | output | 1 | Transaction cancelled, retry required (pulse) |

## Verification
The sweep crosses direction, single and burst length, streaming on and off, zero to two wait cycles per beat, and a data retry placed after every beat position or after none. This separates retries that fall in a wait cycle from retries that land on the next acknowledge, and the final-beat reopen from the case where the retry is ignored because the transfer is a write. Directed runs cover back-to-back starts in the post-final cycle with and without streaming, which show whether busy dropped for one cycle or not at all. Further runs cover a start request while beats are pending, and bus error, address retry and their simultaneous arrival, which shows the priority.

// File: rtl/dpt_pkg.sv
package dpt_pkg;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_DATA   = 2'd1,
        ST_TAIL   = 2'd2,
        ST_REOPEN = 2'd3
    } dpt_state_e;

    function automatic int idx_width(input int beats);
        return (beats > 1) ? $clog2(beats) : 1;
    endfunction

endpackage

// File: rtl/dpt_beat_track.sv
module dpt_beat_track #(
    parameter int IDX_W = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr_i,
    input  logic             abort_i,
    input  logic             take_i,
    input  logic             cancel_i,
    input  logic [IDX_W-1:0] last_idx_i,
    output logic             pend_o,
    output logic [IDX_W-1:0] idx_o,
    output logic             last_hit_o
);
    localparam int CNT_W = IDX_W + 1;

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic             pend;
        logic [IDX_W-1:0] idx;
    } trk_t;

    trk_t trk_d, trk_q;
    logic [CNT_W-1:0] cur_beat;

    always_comb begin
        trk_d    = trk_q;
        // a withdrawn beat is served again under the same number
        cur_beat = cancel_i ? (trk_q.cnt - CNT_W'(1)) : trk_q.cnt;
        if (clr_i || abort_i) begin
            trk_d.cnt  = '0;
            trk_d.pend = 1'b0;
        end else if (take_i) begin
            trk_d.pend = 1'b1;
            trk_d.idx  = cur_beat[IDX_W-1:0];
            trk_d.cnt  = cur_beat + CNT_W'(1);
        end else begin
            trk_d.pend = 1'b0;
            trk_d.cnt  = cur_beat;
        end
        last_hit_o = take_i && (cur_beat == {1'b0, last_idx_i});
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            trk_q <= '0;
        end else begin
            trk_q <= trk_d;
        end
    end

    assign pend_o = trk_q.pend;
    assign idx_o  = trk_q.idx;

endmodule

// File: rtl/dpt_status.sv
module dpt_status (
    input  logic clk,
    input  logic rst_n,
    input  logic done_set_i,
    input  logic err_set_i,
    input  logic rty_set_i,
    output logic done_o,
    output logic err_o,
    output logic retry_o
);
    typedef struct packed {
        logic done;
        logic err;
        logic rty;
    } stat_t;

    stat_t stat_d, stat_q;

    always_comb begin
        stat_d.done = done_set_i;
        stat_d.err  = err_set_i;
        stat_d.rty  = rty_set_i;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stat_q <= '0;
        end else begin
            stat_q <= stat_d;
        end
    end

    assign done_o  = stat_q.done;
    assign err_o   = stat_q.err;
    assign retry_o = stat_q.rty;

endmodule

// File: rtl/dpt_term_ctrl.sv
module dpt_term_ctrl
    import dpt_pkg::*;
#(
    parameter int BURST_BEATS = 4,
    localparam int IDX_W = dpt_pkg::idx_width(BURST_BEATS)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_i,
    input  logic             rd_i,
    input  logic             burst_i,
    input  logic             stream_i,
    input  logic             xfer_ack_i,
    input  logic             data_retry_i,
    input  logic             bus_err_i,
    input  logic             addr_retry_i,
    output logic             bus_busy_o,
    output logic             beat_vld_o,
    output logic [IDX_W-1:0] beat_idx_o,
    output logic             done_o,
    output logic             err_o,
    output logic             retry_o
);
    localparam logic [IDX_W-1:0] LAST_BURST = IDX_W'(BURST_BEATS - 1);

    typedef struct packed {
        dpt_state_e st;
        logic       rd;
        logic       multi;
        logic       strm;
    } ctl_t;

    ctl_t ctl_d, ctl_q;

    logic             pend;
    logic [IDX_W-1:0] pend_idx;
    logic             last_hit;
    logic             in_phase;
    logic             abort;
    logic             cancel;
    logic             take;
    logic             clean_tail;
    logic             accept;
    logic             done_set;
    logic             err_set;
    logic             rty_set;
    logic [IDX_W-1:0] last_idx;

    always_comb begin
        in_phase   = (ctl_q.st != ST_IDLE);
        abort      = in_phase && (bus_err_i || addr_retry_i);
        cancel     = pend && ctl_q.rd && data_retry_i;
        take       = ((ctl_q.st == ST_DATA) || (ctl_q.st == ST_REOPEN))
                     && xfer_ack_i && !abort;
        clean_tail = (ctl_q.st == ST_TAIL) && !abort && !cancel;
        accept     = start_i && ((ctl_q.st == ST_IDLE) || clean_tail);
        last_idx   = ctl_q.multi ? LAST_BURST : '0;

        done_set   = clean_tail;
        err_set    = abort && bus_err_i;
        rty_set    = abort && !bus_err_i;

        ctl_d = ctl_q;
        unique case (ctl_q.st)
            ST_IDLE: begin
                if (accept) begin
                    ctl_d.st    = ST_DATA;
                    ctl_d.rd    = rd_i;
                    ctl_d.multi = burst_i;
                    ctl_d.strm  = stream_i;
                end
            end
            ST_DATA: begin
                if (abort) begin
                    ctl_d.st = ST_IDLE;
                end else if (last_hit) begin
                    ctl_d.st = ST_TAIL;
                end
            end
            ST_TAIL: begin
                if (abort) begin
                    ctl_d.st = ST_IDLE;
                end else if (cancel) begin
                    ctl_d.st = ST_REOPEN;
                end else if (accept) begin
                    ctl_d.st    = ST_DATA;
                    ctl_d.rd    = rd_i;
                    ctl_d.multi = burst_i;
                    ctl_d.strm  = stream_i;
                end else begin
                    ctl_d.st = ST_IDLE;
                end
            end
            ST_REOPEN: begin
                if (abort) begin
                    ctl_d.st = ST_IDLE;
                end else if (last_hit) begin
                    ctl_d.st = ST_TAIL;
                end
            end
            default: ctl_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctl_q <= '{st: ST_IDLE, rd: 1'b0, multi: 1'b0, strm: 1'b0};
        end else begin
            ctl_q <= ctl_d;
        end
    end

    dpt_beat_track #(
        .IDX_W(IDX_W)
    ) u_track (
        .clk       (clk),
        .rst_n     (rst_n),
        .clr_i     (accept),
        .abort_i   (abort),
        .take_i    (take),
        .cancel_i  (cancel),
        .last_idx_i(last_idx),
        .pend_o    (pend),
        .idx_o     (pend_idx),
        .last_hit_o(last_hit)
    );

    dpt_status u_status (
        .clk       (clk),
        .rst_n     (rst_n),
        .done_set_i(done_set),
        .err_set_i (err_set),
        .rty_set_i (rty_set),
        .done_o    (done_o),
        .err_o     (err_o),
        .retry_o   (retry_o)
    );

    assign bus_busy_o = (ctl_q.st == ST_DATA) || ((ctl_q.st == ST_TAIL) && ctl_q.strm);
    assign beat_vld_o = pend && !cancel && !abort;
    assign beat_idx_o = pend_idx;

endmodule

// File: rtl/dpt_term_chk.sv
module dpt_term_chk (
    input logic clk,
    input logic rst_n,
    input logic start_i,
    input logic xfer_ack_i,
    input logic bus_err_i,
    input logic addr_retry_i,
    input logic bus_busy_o,
    input logic beat_vld_o,
    input logic done_o,
    input logic err_o,
    input logic retry_o
);
    // R3: a forwarded beat always follows an acknowledge
    a_r3_vld_after_ack: assert property (@(posedge clk) disable iff (!rst_n)
        beat_vld_o |-> $past(xfer_ack_i));

    // R2: busy only rises after a start request or a reopened beat's acknowledge
    a_r2_busy_rise: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(bus_busy_o) |-> ($past(start_i) || $past(xfer_ack_i)));

    // R8: at most one kind of end status at a time
    a_r8_one_status: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({done_o, err_o, retry_o}));

    // R8: completion never lasts two cycles
    a_r8_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);

    // R9: error status follows a bus error with no data in that cycle
    a_r9_err_cause: assert property (@(posedge clk) disable iff (!rst_n)
        err_o |-> ($past(bus_err_i) && !$past(beat_vld_o)));

    // R10 / R11: retry status follows an address retry without a bus error
    a_r10_rty_cause: assert property (@(posedge clk) disable iff (!rst_n)
        retry_o |-> ($past(addr_retry_i) && !$past(bus_err_i) && !$past(beat_vld_o)));

endmodule

bind dpt_term_ctrl dpt_term_chk u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .start_i     (start_i),
    .xfer_ack_i  (xfer_ack_i),
    .bus_err_i   (bus_err_i),
    .addr_retry_i(addr_retry_i),
    .bus_busy_o  (bus_busy_o),
    .beat_vld_o  (beat_vld_o),
    .done_o      (done_o),
    .err_o       (err_o),
    .retry_o     (retry_o)
);

// File: tb/dpt_term_ctrl_test.sv
`timescale 1ns/1ps
module dpt_term_ctrl_test;
    localparam int BEATS = 4;
    localparam int IW    = 2;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start_i = 0, rd_i = 0, burst_i = 0, stream_i = 0;
    logic xfer_ack_i = 0, data_retry_i = 0, bus_err_i = 0, addr_retry_i = 0;
    logic bus_busy_o, beat_vld_o, done_o, err_o, retry_o;
    logic [IW-1:0] beat_idx_o;

    int total = 0;
    int fails = 0;
    bit pend = 0;
    int pidx = 0;
    bit cur_rd = 0;
    bit finished = 0;

    always #4 clk = ~clk;

    dpt_term_ctrl #(.BURST_BEATS(BEATS)) uut (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .rd_i(rd_i),
        .burst_i(burst_i), .stream_i(stream_i), .xfer_ack_i(xfer_ack_i),
        .data_retry_i(data_retry_i), .bus_err_i(bus_err_i),
        .addr_retry_i(addr_retry_i), .bus_busy_o(bus_busy_o),
        .beat_vld_o(beat_vld_o), .beat_idx_o(beat_idx_o), .done_o(done_o),
        .err_o(err_o), .retry_o(retry_o)
    );

    task automatic chk(bit ok, string tag, string what, int act, int exp);
        total++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: got %0d expected %0d", tag, what, act, exp);
        end
    endtask

    // one cycle: drive at the falling edge, check 1 ns later
    task automatic cyc(bit st, bit ack, int idx, bit dr, bit be, bit ar,
                       bit eb, bit ed, bit ee, bit er, string bt);
        bit ev;
        string vt;
        start_i = st; xfer_ack_i = ack; data_retry_i = dr;
        bus_err_i = be; addr_retry_i = ar;
        #1;
        ev = pend && !(cur_rd && dr) && !be && !ar;
        vt = (dr && cur_rd) ? "R4" : (dr ? "R5" : "R3");
        chk(bus_busy_o == eb, bt, "bus_busy_o", bus_busy_o, eb);
        chk(beat_vld_o == ev, vt, "beat_vld_o", beat_vld_o, ev);
        if (ev) chk(int'(beat_idx_o) == pidx, vt, "beat_idx_o", beat_idx_o, pidx);
        chk(done_o == ed, "R8", "done_o", done_o, ed);
        chk(err_o == ee, "R9", "err_o", err_o, ee);
        chk(retry_o == er, "R10", "retry_o", retry_o, er);
        pend = ack && !be && !ar;
        pidx = idx;
        @(negedge clk);
    endtask

    task automatic setup(bit rd, bit bu, bit sm);
        rd_i = rd; burst_i = bu; stream_i = sm; cur_rd = rd;
    endtask

    // full transfer; rb = beat followed by a data retry, -1 for none
    task automatic xfer(bit rd, bit bu, bit sm, int wt, int rb);
        int n = bu ? BEATS : 1;
        bit drn = 0;
        setup(rd, bu, sm);
        cyc(1, 0, 0, 0, 0, 0, 0, 0, 0, 0, "R2");
        for (int b = 0; b < n; b++) begin
            int reps = (b == rb && rd && b < n - 1) ? 2 : 1;
            for (int r = 0; r < reps; r++) begin
                for (int k = 0; k < wt; k++) begin
                    cyc(0, 0, 0, drn, 0, 0, 1, 0, 0, 0, "R2");
                    drn = 0;
                end
                cyc(0, 1, b, drn, 0, 0, 1, 0, 0, 0, "R2");
                drn = (b == rb && r == 0);
            end
        end
        if (rd && rb == n - 1) begin
            // R7: reopened final beat, busy already released
            cyc(0, 0, 0, 1, 0, 0, sm, 0, 0, 0, "R7");
            for (int k = 0; k < wt; k++) cyc(0, 0, 0, 0, 0, 0, 0, 0, 0, 0, "R7");
            cyc(0, 1, n - 1, 0, 0, 0, 0, 0, 0, 0, "R7");
            drn = 0;
        end
        cyc(0, 0, 0, drn, 0, 0, sm, 0, 0, 0, "R6");
        cyc(0, 0, 0, 0, 0, 0, 0, 1, 0, 0, "R8");
        cyc(0, 0, 0, 0, 0, 0, 0, 0, 0, 0, "R8");
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            total++; fails++;
            $display("FAIL watchdog: got %0d expected %0d", 0, 1);
            $display("%0d/%0d checks passed", total - fails, total);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        #1;
        chk(!bus_busy_o && !beat_vld_o && !done_o && !err_o && !retry_o,
            "R1", "outputs in reset", {bus_busy_o, beat_vld_o, done_o, err_o, retry_o}, 0);
        @(negedge clk);
        rst_n = 1'b1;
        #1;
        chk(!bus_busy_o && !beat_vld_o && !done_o && !err_o && !retry_o,
            "R1", "outputs after reset", {bus_busy_o, beat_vld_o, done_o, err_o, retry_o}, 0);
        @(negedge clk);

        // sweep: direction x length x streaming x wait states x retry position
        for (int rd = 0; rd < 2; rd++)
            for (int bu = 0; bu < 2; bu++)
                for (int sm = 0; sm < 2; sm++)
                    for (int wt = 0; wt < 3; wt++)
                        for (int rb = -1; rb < (bu ? BEATS : 1); rb++)
                            xfer(rd[0], bu[0], sm[0], wt, rb);

        // R2: start during beats is ignored, single beat stays single
        setup(1, 0, 0);
        cyc(1, 0, 0, 0, 0, 0, 0, 0, 0, 0, "R2");
        burst_i = 1;
        cyc(1, 0, 0, 0, 0, 0, 1, 0, 0, 0, "R2");
        cyc(0, 1, 0, 0, 0, 0, 1, 0, 0, 0, "R2");
        cyc(0, 0, 0, 0, 0, 0, 0, 0, 0, 0, "R2");
        cyc(0, 0, 0, 0, 0, 0, 0, 1, 0, 0, "R2");
        cyc(0, 0, 0, 0, 0, 0, 0, 0, 0, 0, "R2");

        // R6: back-to-back without streaming, busy low exactly one cycle
        setup(0, 0, 0);
        cyc(1, 0, 0, 0, 0, 0, 0, 0, 0, 0, "R6");
        cyc(0, 1, 0, 0, 0, 0, 1, 0, 0, 0, "R6");
        cyc(1, 0, 0, 0, 0, 0, 0, 0, 0, 0, "R6");
        cyc(0, 1, 0, 0, 0, 0, 1, 1, 0, 0, "R6");
        cyc(0, 0, 0, 0, 0, 0, 0, 0, 0, 0, "R6");
        cyc(0, 0, 0, 0, 0, 0, 0, 1, 0, 0, "R6");

        // R6: back-to-back with streaming, busy never drops
        setup(0, 0, 1);
        cyc(1, 0, 0, 0, 0, 0, 0, 0, 0, 0, "R6");
        cyc(0, 1, 0, 0, 0, 0, 1, 0, 0, 0, "R6");
        cyc(1, 0, 0, 0, 0, 0, 1, 0, 0, 0, "R6");
        cyc(0, 1, 0, 0, 0, 0, 1, 1, 0, 0, "R6");
        cyc(0, 0, 0, 0, 0, 0, 1, 0, 0, 0, "R6");
        cyc(0, 0, 0, 0, 0, 0, 0, 1, 0, 0, "R6");
        stream_i = 0;

        // R9: bus error after first burst beat
        setup(1, 1, 0);
        cyc(1, 0, 0, 0, 0, 0, 0, 0, 0, 0, "R9");
        cyc(0, 1, 0, 0, 0, 0, 1, 0, 0, 0, "R9");
        cyc(0, 0, 0, 0, 1, 0, 1, 0, 0, 0, "R9");
        cyc(0, 0, 0, 0, 0, 0, 0, 0, 1, 0, "R9");
        cyc(0, 0, 0, 0, 0, 0, 0, 0, 0, 0, "R9");

        // R10: address retry after two beats
        setup(1, 1, 0);
        cyc(1, 0, 0, 0, 0, 0, 0, 0, 0, 0, "R10");
        cyc(0, 1, 0, 0, 0, 0, 1, 0, 0, 0, "R10");
        cyc(0, 1, 1, 0, 0, 0, 1, 0, 0, 0, "R10");
        cyc(0, 0, 0, 0, 0, 1, 1, 0, 0, 0, "R10");
        cyc(0, 0, 0, 0, 0, 0, 0, 0, 0, 1, "R10");
        cyc(0, 0, 0, 0, 0, 0, 0, 0, 0, 0, "R10");

        // R11: error, address retry and acknowledge together
        setup(0, 0, 0);
        cyc(1, 0, 0, 0, 0, 0, 0, 0, 0, 0, "R11");
        cyc(0, 1, 0, 0, 1, 1, 1, 0, 0, 0, "R11");
        #1;
        chk(err_o == 1 && retry_o == 0, "R11", "err_o,retry_o", {err_o, retry_o}, 2);
        cyc(0, 0, 0, 0, 0, 0, 0, 0, 1, 0, "R11");
        cyc(0, 0, 0, 0, 0, 0, 0, 0, 0, 0, "R11");

        finished = 1;
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end

endmodule